// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Character Gap

This block turns bytes into asynchronous serial frames on a single output line. A one-byte holding stage accepts a byte from the surrounding logic and reports when it can take another one. The frame sequencer moves the held byte into its shift stage and sends a start bit, the data bits, an optional parity bit and the stop bits. It then holds the line idle for a programmed number of whole bit periods before the next character starts.

All timing comes from a 16x oversampling tick input, and one bit period is 16 of those ticks. Character length, stop-bit count and parity mode are captured when a byte enters the shift stage, so they stay fixed for the whole frame. A break input drives the line low whenever it is set. The request-to-send output follows either a manual level or the transmitter's own activity, with a choice of active level.

Top module: `uart_gap_tx`

## Requirements
- R1: After reset `txd` is 1 (mark), `hold_empty` is 1, and the gap register holds 0x24 (36 bit periods).
- R2: A frame begins with one start bit at 0 lasting exactly 16 ticks of `tick16`. Data bits follow least significant bit first, each 16 ticks long. The idle line is 1.
- R3: `char_len` selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7, 2'b11 gives 8. Only that many low bits of the byte are sent.
- R4: With `stop_sel`=0 the stop level lasts 16 ticks. With `stop_sel`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for the other lengths.
- R5: With `par_en`=1 and `par_force`=0, a 16-tick parity bit follows the data. `par_even`=1 makes the count of ones in data plus parity even, and `par_even`=0 makes it odd.
- R6: With `par_en`=1 and `par_force`=1, the parity bit is 1 when `par_even`=0 and 0 when `par_even`=1, whatever the data.
- R7: While `brk` is 1, `txd` is 0. When `brk` returns to 0 the line shows the transmitter's own level again.
- R8: When a byte is waiting, the mark level between the start of the stop bits and the next start bit lasts the stop length plus 16 times the gap value in ticks. A gap of 0 gives back-to-back frames.
- R9: A cycle with `gap_load`=1 writes `gap_value` into the gap register, which sets the gap for the following characters.
- R10: `hold_empty` is 1 while no byte is held. It is 0 in the cycle after an accepted write. A write while it is 0 is ignored and the ignored byte is never sent.
- R11: With `rts_auto`=1 the request is active while a byte is held or a frame or gap is in progress. With `rts_auto`=0 it follows `rts_manual`. `rts_high`=1 makes active drive `rts` to 1, and `rts_high`=0 makes active drive it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to send |
| char_len | input | 2 | Data bit count select |
| stop_sel | input | 1 | Longer stop selection |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| par_force | input | 1 | Replace computed parity with a fixed level |
| brk | input | 1 | Force the line to 0 |
| gap_load | input | 1 | Write strobe for the gap register |
| gap_value | input | 8 | New gap in bit periods |
| rts_auto | input | 1 | Request follows transmitter activity |
| rts_manual | input | 1 | Manual request level (1 = active) |
| rts_high | input | 1 | 1 = request active high |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding stage can accept a byte |
| rts | output | 1 | Request-to-send output |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, 8-bit data and an 8-bit gap register that resets to 0x24. Sixteen ticks per bit gives a whole-tick half bit, so the 24-tick stop of 5-bit characters can be measured exactly. Keeping the reset gap for the first burst makes the 36-period default visible at the line. A tick every fourth clock keeps a 36-period gap to a few thousand cycles. This leaves room to step through all four lengths, both stop settings, computed and forced parity, zero and non-zero gaps, break, an ignored write and each request mode.

// File: rtl/uart_gap_tx_pkg.sv
// Shared types for the gap-inserting serial transmitter.
package uart_gap_tx_pkg;

    // Frame sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_GAP   = 3'd5
    } tx_state_e;

    // Per-frame format captured when a byte is loaded
    typedef struct packed {
        logic [1:0] len_sel;
        logic       stop_sel;
        logic       par_en;
        logic       par_even;
        logic       par_force;
    } frame_cfg_t;

endpackage

// File: rtl/uart_gap_tx_hold.sv
// One-byte holding stage.
// Accepts a byte when empty and releases it when the sequencer takes it.
// Assumes take is only raised while the stage is full.
module uart_gap_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          hold_full,
    output logic [DW-1:0] hold_data
);

    // Capture a byte when empty, drop it when the sequencer takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (wr_en && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end
    end

    assert_take_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_full);

    assert_keep_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !take) |=> (hold_full && $stable(hold_data)));

endmodule

// File: rtl/uart_gap_tx_seq.sv
// Frame sequencer: start, data (LSB first), optional parity, stop, then gap.
// Every element is timed in 16x ticks. Frame format is latched at load.
// The gap value is sampled when the stop element ends.
// Assumes tick is a single-cycle pulse and DW is at least 8.
module uart_gap_tx_seq
    import uart_gap_tx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8,
    parameter int GW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          brk,
    input  frame_cfg_t    cfg,
    input  logic [GW-1:0] gap,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    output logic          take,
    output logic          txd,
    output logic          busy
);

    localparam int CW = $clog2(2 * OSR);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] LAST_ONE  = CW'(OSR - 1);
    localparam logic [CW-1:0] LAST_HALF = CW'(OSR + OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_TWO  = CW'(2 * OSR - 1);

    tx_state_e     state;
    frame_cfg_t    cfg_q;
    logic [CW-1:0] tcnt;
    logic [CW-1:0] elem_last;
    logic [BW-1:0] bidx;
    logic [BW-1:0] bidx_last;
    logic [DW-1:0] shreg;
    logic [GW-1:0] gcnt;
    logic          par_acc;
    logic          par_bit;
    logic          elem_end;
    logic          frame_done;
    logic          line;

    // Tick index of the last tick in the current element
    always_comb begin
        elem_last = LAST_ONE;
        if (state == ST_STOP && cfg_q.stop_sel)
            elem_last = (cfg_q.len_sel == 2'b00) ? LAST_HALF : LAST_TWO;
    end

    assign elem_end  = tick && (tcnt == elem_last);
    assign bidx_last = BW'(4) + BW'(cfg_q.len_sel);

    // Frame ends after stop with no gap, or after the final gap period
    assign frame_done = elem_end &&
                        ((state == ST_STOP && gap == '0) ||
                         (state == ST_GAP && gcnt == GW'(1)));

    assign take = hold_full && (state == ST_IDLE || frame_done);
    assign busy = (state != ST_IDLE);

    // Parity level: fixed when forced, otherwise completes even/odd count
    assign par_bit = cfg_q.par_force ? ~cfg_q.par_even
                                     : (par_acc ^ ~cfg_q.par_even);

    // Line level from the current element
    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_bit;
            default:  line = 1'b1;
        endcase
    end

    assign txd = brk ? 1'b0 : line;

    // State, tick counter, shift register and gap counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            gcnt    <= '0;
            par_acc <= 1'b0;
        end else if (take) begin
            state   <= ST_START;
            cfg_q   <= cfg;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= hold_data;
            par_acc <= 1'b0;
        end else if (tick) begin
            tcnt <= elem_end ? '0 : tcnt + CW'(1);
            if (elem_end) begin
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        par_acc <= par_acc ^ shreg[0];
                        shreg   <= shreg >> 1;
                        bidx    <= bidx + BW'(1);
                        if (bidx == bidx_last)
                            state <= cfg_q.par_en ? ST_PAR : ST_STOP;
                    end
                    ST_PAR:   state <= ST_STOP;
                    ST_STOP: begin
                        if (gap == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_GAP;
                            gcnt  <= gap;
                        end
                    end
                    ST_GAP: begin
                        if (gcnt == GW'(1)) state <= ST_IDLE;
                        else                gcnt  <= gcnt - GW'(1);
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_start_waits_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && !tick) |=> (state == ST_START));

    assert_gap_zero_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && elem_end && gap == '0 && hold_full) |=> (state == ST_START));

endmodule

// File: rtl/uart_gap_tx_rts.sv
// Request-to-send output selection.
// Active level follows either activity or a manual bit, then polarity.
module uart_gap_tx_rts (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_auto,
    input  logic rts_manual,
    input  logic rts_high,
    input  logic hold_full,
    input  logic busy,
    output logic rts
);

    logic active;

    // Pick the request source, then apply polarity
    always_comb begin
        active = rts_auto ? (hold_full || busy) : rts_manual;
        rts    = rts_high ? active : ~active;
    end

    assert_rts_auto_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto && !rts_high && hold_full) |-> !rts);

endmodule

// File: rtl/uart_gap_tx.sv
// Top: asynchronous serial transmitter with programmable character gap.
// Holds one byte, frames it from 16x ticks, and inserts idle bit periods.
// Assumes tick16 is a one-cycle pulse and the bit rate is set outside.
module uart_gap_tx
    import uart_gap_tx_pkg::*;
#(
    parameter int          OSR       = 16,
    parameter int          DW        = 8,
    parameter int          GW        = 8,
    parameter logic [GW-1:0] GAP_RESET = GW'(8'h24)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    char_len,
    input  logic          stop_sel,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          par_force,
    input  logic          brk,
    input  logic          gap_load,
    input  logic [GW-1:0] gap_value,
    input  logic          rts_auto,
    input  logic          rts_manual,
    input  logic          rts_high,
    output logic          txd,
    output logic          hold_empty,
    output logic          rts
);

    logic [GW-1:0] gap_q;
    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          take;
    logic          busy;
    frame_cfg_t    cfg;

    // Gap register, written by its load strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        gap_q <= GAP_RESET;
        else if (gap_load) gap_q <= gap_value;
    end

    // Gather the format inputs into one word
    always_comb begin
        cfg.len_sel   = char_len;
        cfg.stop_sel  = stop_sel;
        cfg.par_en    = par_en;
        cfg.par_even  = par_even;
        cfg.par_force = par_force;
    end

    assign hold_empty = ~hold_full;

    uart_gap_tx_hold #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_full (hold_full),
        .hold_data (hold_data)
    );

    uart_gap_tx_seq #(.OSR(OSR), .DW(DW), .GW(GW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .brk       (brk),
        .cfg       (cfg),
        .gap       (gap_q),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .txd       (txd),
        .busy      (busy)
    );

    uart_gap_tx_rts u_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .rts_auto   (rts_auto),
        .rts_manual (rts_manual),
        .rts_high   (rts_high),
        .hold_full  (hold_full),
        .busy       (busy),
        .rts        (rts)
    );

    assert_break_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    assert_write_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_empty) |=> !hold_empty);

endmodule

// File: tb/uart_gap_tx_tb.sv
`timescale 1ns/1ps
module uart_gap_tx_tb;

    typedef struct {
        logic [7:0] data;
        int         nb;
        bit         pe;
        logic       pbit;
        int         stop_t;
        int         hi_exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] char_len = 2'b11;
    logic       stop_sel = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_force = 1'b0;
    logic       brk = 1'b0;
    logic       gap_load = 1'b0;
    logic [7:0] gap_value = '0;
    logic       rts_auto = 1'b0;
    logic       rts_manual = 1'b0;
    logic       rts_high = 1'b0;
    logic       txd;
    logic       hold_empty;
    logic       rts;

    int    checks = 0;
    int    fails = 0;
    int    sent = 0;
    int    done = 0;
    int    gap_cur = 36;
    bit    finished = 1'b0;
    item_t q[$];

    uart_gap_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .char_len(char_len), .stop_sel(stop_sel), .par_en(par_en), .par_even(par_even),
        .par_force(par_force), .brk(brk), .gap_load(gap_load), .gap_value(gap_value),
        .rts_auto(rts_auto), .rts_manual(rts_manual), .rts_high(rts_high),
        .txd(txd), .hold_empty(hold_empty), .rts(rts)
    );

    always #2.5 clk = ~clk;

    // 16x tick: one cycle in four
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // Driver: push the expected frame, then write when the stage is empty
    task automatic send(input logic [7:0] d, input bit chk);
        item_t it;
        logic  x;
        it.nb = 5 + int'(char_len);
        it.data = d & ((8'd1 << it.nb) - 8'd1);
        x = ^it.data;
        it.pe = par_en;
        it.pbit = par_force ? ~par_even : (par_even ? x : ~x);
        it.stop_t = stop_sel ? ((char_len == 2'b00) ? 24 : 32) : 16;
        it.hi_exp = chk ? it.stop_t + gap_cur * 16 : -1;
        q.push_back(it);
        sent++;
        @(negedge clk);
        while (!hold_empty) @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(hold_empty == 1'b0, "R10 holding flag drops after write", int'(hold_empty), 0);
    endtask

    task automatic wait_done();
        while (done != sent) @(negedge clk);
    endtask

    task automatic set_gap(input int g);
        @(negedge clk);
        gap_load = 1'b1;
        gap_value = 8'(g);
        @(negedge clk);
        gap_load = 1'b0;
        gap_cur = g;
    endtask

    // One line sample per tick, skipping break cycles
    task automatic get_sample(output logic v);
        do begin
            @(negedge clk);
            #1;
        end while (!(tick16 && !brk));
        v = txd;
    endtask

    // Monitor: decode frames tick by tick and compare with the queue
    initial begin : monitor
        int         pend;
        int         hi;
        int         lows;
        int         h;
        logic       v;
        logic       f;
        logic [7:0] rx;
        bit         cons;
        item_t      it;
        pend = -1;
        wait (rst_n);
        forever begin
            hi = 0;
            get_sample(v);
            while (v) begin
                hi++;
                get_sample(v);
            end
            if (pend >= 0) check(hi == pend, "R8 mark run between frames", hi, pend);
            pend = -1;
            if (q.size() == 0) begin
                check(1'b0, "R10 start bit with no queued byte", 1, 0);
                continue;
            end
            it = q.pop_front();
            lows = 1;
            for (int i = 1; i < 16; i++) begin
                get_sample(v);
                if (!v) lows++;
            end
            check(lows == 16, "R2 start bit ticks", lows, 16);
            rx = '0;
            cons = 1'b1;
            for (int b = 0; b < it.nb; b++) begin
                get_sample(f);
                rx[b] = f;
                for (int k = 1; k < 16; k++) begin
                    get_sample(v);
                    if (v !== f) cons = 1'b0;
                end
            end
            check(rx == it.data && cons, "R3 data bits LSB first", int'(rx), int'(it.data));
            if (it.pe) begin
                cons = 1'b1;
                get_sample(f);
                for (int k = 1; k < 16; k++) begin
                    get_sample(v);
                    if (v !== f) cons = 1'b0;
                end
                check(f == it.pbit && cons, "R5/R6 parity bit", int'(f), int'(it.pbit));
            end
            if (it.hi_exp >= 0) begin
                pend = it.hi_exp;
            end else begin
                h = 0;
                for (int k = 0; k < it.stop_t; k++) begin
                    get_sample(v);
                    if (v) h++;
                end
                check(h == it.stop_t, "R4 stop ticks", h, it.stop_t);
            end
            done++;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", done, sent);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1 line idles at mark after reset", int'(txd), 1);
        check(hold_empty == 1'b1, "R1 holding stage empty after reset", int'(hold_empty), 1);
        check(rts == 1'b1, "R11 manual inactive, active-low gives 1", int'(rts), 1);

        // R1: reset gap 0x24 -> 16 + 36*16 = 592 mark ticks; 8 bits, no parity
        send(8'hA5, 1'b1);
        send(8'h3C, 1'b0);
        wait_done();

        // R9: loaded gap 2; 5-bit, 1.5 stop (R4), even parity (R5)
        set_gap(2);
        char_len = 2'b00; stop_sel = 1'b1; par_en = 1'b1; par_even = 1'b1; par_force = 1'b0;
        send(8'h13, 1'b1);
        send(8'h0E, 1'b1);
        send(8'h1F, 1'b0);
        wait_done();

        // R3 R4 R5: 7-bit, two stops, odd parity
        char_len = 2'b10; stop_sel = 1'b1; par_even = 1'b0;
        send(8'h55, 1'b1);
        send(8'hFF, 1'b0);
        wait_done();

        // R6: 6-bit forced parity, odd select then even select
        char_len = 2'b01; stop_sel = 1'b0; par_force = 1'b1; par_even = 1'b0;
        send(8'h2A, 1'b1);
        send(8'h15, 1'b0);
        wait_done();
        par_even = 1'b1;
        send(8'h3F, 1'b1);
        send(8'h00, 1'b0);
        wait_done();

        // R8: gap 0, back-to-back 8-bit frames
        set_gap(0);
        char_len = 2'b11; stop_sel = 1'b0; par_en = 1'b0; par_force = 1'b0;
        send(8'h01, 1'b1);
        send(8'h80, 1'b1);
        send(8'hFF, 1'b0);
        wait_done();

        // R10: write while full is ignored
        set_gap(3);
        send(8'hC3, 1'b1);
        send(8'h96, 1'b0);
        check(hold_empty == 1'b0, "R10 stage still full before extra write", int'(hold_empty), 0);
        wr_en = 1'b1;
        wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        wait_done();
        repeat (2000) @(negedge clk);
        check(hold_empty == 1'b1, "R10 ignored byte left stage empty", int'(hold_empty), 1);
        check(q.size() == 0 && done == sent, "R10 no extra frame sent", done, sent);

        // R7: break forces space, release restores mark
        @(negedge clk);
        brk = 1'b1;
        repeat (5) @(negedge clk);
        check(txd == 1'b0, "R7 break drives line low", int'(txd), 0);
        repeat (30) @(negedge clk);
        check(txd == 1'b0, "R7 line stays low during break", int'(txd), 0);
        brk = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R7 line returns to mark", int'(txd), 1);

        // R11: automatic and manual request modes, both polarities
        set_gap(0);
        rts_auto = 1'b1;
        rts_high = 1'b0;
        @(negedge clk);
        check(rts == 1'b1, "R11 auto idle active-low inactive", int'(rts), 1);
        send(8'h5A, 1'b0);
        check(rts == 1'b0, "R11 auto active while sending", int'(rts), 0);
        wait_done();
        repeat (10) @(negedge clk);
        check(rts == 1'b1, "R11 auto inactive after frame", int'(rts), 1);
        rts_high = 1'b1;
        @(negedge clk);
        check(rts == 1'b0, "R11 auto idle active-high inactive", int'(rts), 0);
        rts_auto = 1'b0;
        rts_manual = 1'b1;
        @(negedge clk);
        check(rts == 1'b1, "R11 manual active-high", int'(rts), 1);
        rts_high = 1'b0;
        @(negedge clk);
        check(rts == 1'b0, "R11 manual active-low", int'(rts), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule